// File: doc/BRIEF.md
# Transparent Online RAM Test Engine

This block is a hardware self-test controller placed between the system arbiter and a single-port synchronous RAM. It can run while the system keeps using the memory. A run starts with a pulse on `start` and ends when `done` rises. The run has two phases. The first phase checks the address lines. The second phase checks the data cells, a few cells at a time. Each group of cells is copied into internal registers before it is overwritten, and the copy is written back afterwards. The contents the system relies on are therefore the same after a run as before it.

The address-line phase uses the base cell 0 and every cell whose address has exactly one bit set. It writes a distinct value into each of these cells. It reads any of them back only after all of them have been written. A stuck or bridged address line makes two of these writes land on one physical cell, and the read-back then shows the error.

The data phase walks the RAM in ascending windows of `WIN` cells. For each window it saves the cells, clears them, writes an alternating bit pattern, verifies it, writes the inverse pattern and verifies that. It then puts the saved contents back. The system can only be held off at the start of a window: the engine waits there until `chunk_grant` is high. The first miscompare raises `fail` and stores the address and the data read back. The engine then restores the current group of cells and stops.

Top module: `ramtest_engine`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `mem_req` and `mem_we` are all low.
- R2: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high until the run ends. `done` rises in the cycle `busy` falls. `busy` and `done` are never high together. `done` stays high until the next accepted `start`.
- R3: The address-line phase covers `AW+1` cells with index i. Index 0 is cell 0, and index i>0 is cell 2^(i-1). The phase first reads all of these cells, then writes the value i+1 into each, then reads each back in index order. The saved contents are written back last. A line k that is stuck low or stuck high makes the first read-back fail: `fail_addr` is 0 and `fail_data` is k+2.
- R4: Each data window covers `WIN` consecutive cells starting at a multiple of `WIN`. The order of operations is:
  - read (save) the cells,
  - write 0,
  - write the pattern made of the bit pair 01 repeated (0x55 for 8 bits),
  - read and compare,
  - write the inverse pattern (0xAA),
  - read and compare,
  - write the saved values.

  Windows run in ascending order until the last cell has been covered.
- R5: A cell with a data bit stuck at 0 or 1 is reported. `fail_addr` is that cell. `fail_data` is the value read back in the first verify step that sees the stuck bit differ from the pattern.
- R6: When a run ends, every RAM cell holds the value it held before the run. This holds whether the run passes or fails.
- R7: After a miscompare the engine writes no cell outside the current window. It restores that window and ends the run.
- R8: While the engine is between windows and `chunk_grant` is low, `mem_req` stays low.
- R9: `fail`, `fail_addr` and `fail_data` keep the first miscompare until the next accepted `start`, which clears `fail`.
- R10: `mem_we` is high only while `mem_req` is high. Reads return data one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| chunk_grant | input | 1 | Allows the next window to begin |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | A miscompare was seen in this run |
| fail_addr | output | AW | Address of the first miscompare |
| fail_data | output | DW | Data read at the first miscompare |
| mem_req | output | 1 | Engine drives the RAM this cycle |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, one cycle after a read request |

## Verification
The bench models the RAM with random contents. It can inject one fault into this model:
- An address line stuck low or stuck high. This shows whether the distinct-value writes detect the aliasing and report cell 0 with the value of the aliased write.
- A data bit stuck at 0 or 1 in a cell that is not used by the address-line phase. This tells the two verify steps apart, because the bit position and stuck value decide which pattern exposes the fault. It also tests that no write goes past the failing window.

Clean runs with a random `chunk_grant` show that memory is preserved and every window is covered. A recorded trace of the first 64 accesses checks the exact order of the address-line operations and of the first window against the sequence computed in the bench.

// File: rtl/ramtest_pkg.sv
package ramtest_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SAVE,
      ST_ALWR,
      ST_ALRD,
      ST_CLR,
      ST_W55,
      ST_R55,
      ST_WAA,
      ST_RAA,
      ST_REST,
      ST_FIN
   } rt_state_e;

   // step that follows a completed group of accesses
   function automatic rt_state_e next_step(input rt_state_e s, input logic al);
      case (s)
         ST_SAVE: return al ? ST_ALWR : ST_CLR;
         ST_ALWR: return ST_ALRD;
         ST_CLR:  return ST_W55;
         ST_W55:  return ST_R55;
         ST_R55:  return ST_WAA;
         ST_WAA:  return ST_RAA;
         default: return ST_REST;
      endcase
   endfunction

endpackage

// File: rtl/ramtest_ctrl.sv
module ramtest_ctrl
   import ramtest_pkg::*;
#(
   parameter int AW  = 8,
   parameter int WIN = 4,
   parameter int NAL = 9,
   parameter int IW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          chunk_grant,
   input  logic          miscmp,
   input  logic          fail,
   output rt_state_e     state,
   output logic          al_mode,
   output logic [IW-1:0] idx,
   output logic [AW-1:0] base,
   output logic          done
);
   localparam int DEPTH = 2 ** AW;
   localparam logic [AW-1:0] LAST_BASE = AW'(DEPTH - WIN);

   logic idx_last;
   logic fail_now;

   assign idx_last = (idx == (al_mode ? IW'(NAL - 1) : IW'(WIN - 1)));
   assign fail_now = fail | miscmp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         al_mode <= 1'b0;
         idx     <= '0;
         base    <= '0;
         done    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_WAIT;
                  al_mode <= 1'b1;
                  base    <= '0;
                  idx     <= '0;
                  done    <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (chunk_grant) begin
                  state <= ST_SAVE;
                  idx   <= '0;
               end
            end
            ST_REST: begin
               if (idx_last) begin
                  idx <= '0;
                  if (fail_now || (!al_mode && base == LAST_BASE)) begin
                     state <= ST_FIN;
                  end else begin
                     state <= ST_WAIT;
                     if (al_mode) al_mode <= 1'b0;
                     else         base    <= base + AW'(WIN);
                  end
               end else begin
                  idx <= idx + IW'(1);
               end
            end
            ST_FIN: begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            default: begin
               if (miscmp) begin
                  state <= ST_REST;
                  idx   <= '0;
               end else if (idx_last) begin
                  state <= next_step(state, al_mode);
                  idx   <= '0;
               end else begin
                  idx <= idx + IW'(1);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/ramtest_addrgen.sv
module ramtest_addrgen
   import ramtest_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter int IW = 4
) (
   input  rt_state_e     state,
   input  logic          al_mode,
   input  logic [IW-1:0] idx,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] pat
);
   localparam logic [DW-1:0] P55 = {(DW / 2){2'b01}};
   localparam logic [DW-1:0] PAA = ~P55;

   logic [DW-1:0] uniq;

   assign uniq = DW'(idx) + DW'(1);

   always_comb begin
      if (al_mode) begin
         addr = (idx == '0) ? '0 : (AW'(1) << (idx - IW'(1)));
      end else begin
         addr = base + AW'(idx);
      end
   end

   // same value serves as write data and as expected read-back
   always_comb begin
      case (state)
         ST_ALWR, ST_ALRD: pat = uniq;
         ST_W55,  ST_R55:  pat = P55;
         ST_WAA,  ST_RAA:  pat = PAA;
         default:          pat = '0;
      endcase
   end

endmodule

// File: rtl/ramtest_hold.sv
module ramtest_hold #(
   parameter int DW    = 8,
   parameter int NSLOT = 9,
   parameter int IW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          save_rd,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] hold_out
);
   logic                  cap_v;
   logic [IW-1:0]         cap_idx;
   logic [NSLOT*DW-1:0]   flat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_v   <= 1'b0;
         cap_idx <= '0;
      end else begin
         cap_v   <= save_rd;
         cap_idx <= idx;
      end
   end

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                            slot_q <= '0;
         else if (cap_v && cap_idx == IW'(g))   slot_q <= rdata;
      end
      assign flat[g*DW +: DW] = slot_q;
   end

   always_comb begin
      hold_out = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (idx == IW'(i)) hold_out = flat[i*DW +: DW];
      end
   end

endmodule

// File: rtl/ramtest_check.sv
module ramtest_check #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          rd_issue,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_exp,
   input  logic [DW-1:0] mem_rdata,
   output logic          miscmp,
   output logic          fail,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_data
);
   logic          pend_q;
   logic [AW-1:0] pend_addr;
   logic [DW-1:0] pend_exp;

   assign miscmp = pend_q && !fail && (mem_rdata != pend_exp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_addr <= '0;
         pend_exp  <= '0;
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_data <= '0;
      end else begin
         pend_q    <= rd_issue;
         pend_addr <= rd_addr;
         pend_exp  <= rd_exp;
         if (clr) begin
            fail <= 1'b0;
         end else if (miscmp) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr;
            fail_data <= mem_rdata;
         end
      end
   end

endmodule

// File: rtl/ramtest_engine.sv
module ramtest_engine
   import ramtest_pkg::*;
#(
   parameter int AW  = 8,
   parameter int DW  = 8,
   parameter int WIN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          chunk_grant,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_data,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int NAL   = AW + 1;
   localparam int NSLOT = (WIN > NAL) ? WIN : NAL;
   localparam int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;

   if (DW % 2 != 0) begin : g_bad_dw
      $error("data width must be even");
   end
   if (WIN < 1 || (WIN & (WIN - 1)) != 0 || WIN > (2 ** AW)) begin : g_bad_win
      $error("window must be a power of two no larger than the RAM");
   end
   if (DW < 31 && (AW + 2) > (2 ** DW)) begin : g_bad_uniq
      $error("data width too small for distinct address-line values");
   end

   rt_state_e     state;
   logic          al_mode;
   logic [IW-1:0] idx;
   logic [AW-1:0] base;
   logic [DW-1:0] pat;
   logic [DW-1:0] hold_out;
   logic          miscmp;
   logic          rd_issue;
   logic          clr;

   assign busy     = (state != ST_IDLE);
   assign clr      = start && (state == ST_IDLE);
   assign mem_req  = state inside {ST_SAVE, ST_ALWR, ST_ALRD, ST_CLR, ST_W55,
                                   ST_R55, ST_WAA, ST_RAA, ST_REST};
   assign mem_we   = state inside {ST_ALWR, ST_CLR, ST_W55, ST_WAA, ST_REST};
   assign rd_issue = state inside {ST_ALRD, ST_R55, ST_RAA};
   assign mem_wdata = (state == ST_REST) ? hold_out : pat;

   ramtest_ctrl #(.AW(AW), .WIN(WIN), .NAL(NAL), .IW(IW)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start(start), .chunk_grant(chunk_grant),
      .miscmp(miscmp), .fail(fail), .state(state), .al_mode(al_mode),
      .idx(idx), .base(base), .done(done)
   );

   ramtest_addrgen #(.AW(AW), .DW(DW), .IW(IW)) addr_i (
      .state(state), .al_mode(al_mode), .idx(idx), .base(base),
      .addr(mem_addr), .pat(pat)
   );

   ramtest_hold #(.DW(DW), .NSLOT(NSLOT), .IW(IW)) hold_i (
      .clk(clk), .rst_n(rst_n), .save_rd(state == ST_SAVE), .idx(idx),
      .rdata(mem_rdata), .hold_out(hold_out)
   );

   ramtest_check #(.AW(AW), .DW(DW)) chk_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rd_issue(rd_issue),
      .rd_addr(mem_addr), .rd_exp(pat), .mem_rdata(mem_rdata),
      .miscmp(miscmp), .fail(fail), .fail_addr(fail_addr),
      .fail_data(fail_data)
   );

endmodule

// File: rtl/ramtest_engine_chk.sv
module ramtest_engine_chk #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          chunk_grant,
   input logic          busy,
   input logic          done,
   input logic          fail,
   input logic [AW-1:0] fail_addr,
   input logic [DW-1:0] fail_data,
   input logic          mem_req,
   input logic          mem_we
);

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy && !done && !fail && !mem_req));

   // R2
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R2
   done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_req && !chunk_grant) |=> !mem_req);

   // R9
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_data)));

   // R10
   we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

endmodule

bind ramtest_engine ramtest_engine_chk #(.AW(AW), .DW(DW)) engine_chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .chunk_grant(chunk_grant),
   .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
   .fail_data(fail_data), .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/ramtest_engine_tb_top.sv
module ramtest_engine_tb_top;
   localparam int AW    = 8;
   localparam int DW    = 8;
   localparam int WIN   = 4;
   localparam int DEPTH = 2 ** AW;
   localparam int NAL   = AW + 1;
   localparam logic [DW-1:0] P55 = {(DW / 2){2'b01}};
   localparam logic [DW-1:0] PAA = ~P55;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic chunk_grant = 1'b1;
   logic busy, done, fail, mem_req, mem_we;
   logic [AW-1:0] fail_addr, mem_addr;
   logic [DW-1:0] fail_data, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   always #4 clk = ~clk;

   ramtest_engine #(.AW(AW), .DW(DW), .WIN(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .chunk_grant(chunk_grant),
      .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
      .fail_data(fail_data), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int vectors = 0;
   int miscompares = 0;

   logic [DW-1:0] mem  [DEPTH];
   logic [DW-1:0] orig [DEPTH];
   bit            aa_seen [DEPTH];
   int  fmode = 0;       // 0 none, 1 addr line low, 2 addr line high, 3 data bit
   int  fk = 0;
   int  fcell = 0;
   logic fv = 1'b0;
   int  gmode = 0;       // 0 grant always, 1 random grant
   int  beyond_lim = DEPTH;
   int  wr_beyond = 0;
   int  we_noreq = 0;
   int  tr_n = 0;
   logic          tr_we   [64];
   logic [AW-1:0] tr_addr [64];
   logic [DW-1:0] tr_data [64];

   function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
      case (fmode)
         1:       return a & ~(AW'(1) << fk);
         2:       return a | (AW'(1) << fk);
         default: return a;
      endcase
   endfunction

   function automatic logic [DW-1:0] stick(input logic [AW-1:0] pa, input logic [DW-1:0] d);
      logic [DW-1:0] r;
      r = d;
      if (fmode == 3 && int'(pa) == fcell) r[fk] = fv;
      return r;
   endfunction

   function automatic bit is_al(input int a);
      return (a & (a - 1)) == 0;
   endfunction

   function automatic logic [AW-1:0] al_addr(input int i);
      return (i == 0) ? '0 : AW'(1) << (i - 1);
   endfunction

   // expected access n of a run: AL phase then window 0
   task automatic exp_op(input int n, output logic we, output logic [AW-1:0] a,
                         output logic [DW-1:0] d);
      int ph, i;
      if (n < 4 * NAL) begin
         ph = n / NAL; i = n % NAL; a = al_addr(i);
         we = (ph == 1 || ph == 3);
         d  = (ph == 1) ? DW'(i + 1) : (ph == 3) ? orig[a] : '0;
      end else begin
         ph = (n - 4 * NAL) / WIN; i = (n - 4 * NAL) % WIN; a = AW'(i);
         case (ph)
            0: begin we = 0; d = '0; end
            1: begin we = 1; d = '0; end
            2: begin we = 1; d = P55; end
            3: begin we = 0; d = '0; end
            4: begin we = 1; d = PAA; end
            5: begin we = 0; d = '0; end
            default: begin we = 1; d = orig[a]; end
         endcase
      end
   endtask

   function automatic logic [DW-1:0] exp_stuck_data(input int b, input logic v);
      logic [DW-1:0] r;
      if (P55[b] != v) begin r = P55; r[b] = v; end
      else begin r = PAA; r[b] = v; end
      return r;
   endfunction

   always @(posedge clk) begin
      if (mem_we && !mem_req) we_noreq++;
      if (mem_req) begin
         if (tr_n < 64) begin
            tr_we[tr_n] = mem_we; tr_addr[tr_n] = mem_addr; tr_data[tr_n] = mem_wdata;
            tr_n++;
         end
         if (mem_we) begin
            mem[phys(mem_addr)] <= stick(phys(mem_addr), mem_wdata);
            if (int'(mem_addr) >= beyond_lim && !is_al(int'(mem_addr))) wr_beyond++;
            if (mem_wdata == PAA) aa_seen[mem_addr] = 1'b1;
         end else begin
            mem_rdata <= mem[phys(mem_addr)];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic prepare(input int m, input int k, input logic v, input int c);
      fmode = m; fk = k; fv = v; fcell = c;
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = stick(AW'(i), DW'($urandom));
         orig[i] = mem[i];
         aa_seen[i] = 1'b0;
      end
      tr_n = 0; wr_beyond = 0;
      beyond_lim = (m == 3) ? ((c / WIN) + 1) * WIN : DEPTH;
   endtask

   task automatic run(input int hold_off, input bit exp_fail, input logic [AW-1:0] ea,
                      input logic [DW-1:0] ed, input string req);
      int cyc = 0;
      bit busy_bad = 0, req_bad = 0, busy_seen = 0;
      int bad = 0, first = -1;
      logic [AW-1:0] fa;
      logic [DW-1:0] fd;
      @(negedge clk);
      chunk_grant = (hold_off > 0) ? 1'b0 : 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 20000) begin
         if (!busy) busy_bad = 1;
         else busy_seen = 1;
         if (cyc < hold_off && mem_req) req_bad = 1;
         if (cyc < hold_off) chunk_grant = 1'b0;
         else chunk_grant = (gmode == 0) ? 1'b1 : ($urandom % 3 != 0);
         @(negedge clk);
         cyc++;
      end
      chunk_grant = 1'b1;
      chk(cyc < 20000, "R2", "run completes", cyc, 20000);
      chk(!busy_bad && busy_seen, "R2", "busy held until done", busy_bad, 0);
      chk(!busy && done, "R2", "busy low with done", busy, 0);
      if (hold_off > 0) chk(!req_bad, "R8", "no access while grant low", req_bad, 0);
      chk(fail == exp_fail, req, "fail flag", fail, exp_fail);
      if (exp_fail) begin
         chk(fail_addr == ea, req, "fail_addr", fail_addr, ea);
         chk(fail_data == ed, req, "fail_data", fail_data, ed);
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (mem[i] !== orig[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      chk(bad == 0, "R6", "contents preserved (first bad cell)", first, -1);
      fa = fail_addr; fd = fail_data;
      repeat (3) @(negedge clk);
      chk(done && fail == exp_fail && fail_addr == fa && fail_data == fd,
          "R9", "result held after done", {done, fail}, {1'b1, exp_fail});
   endtask

   initial begin
      #(8 * 195000);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int k, b, c, errs;
      logic v, we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      void'($urandom(32'h5eed_1234));
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !fail && !mem_req && !mem_we, "R1", "reset outputs",
          {busy, done, fail, mem_req, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_req, "R1", "idle after reset", {busy, done, mem_req}, 0);

      // clean run with initial hold-off, trace recorded
      prepare(0, 0, 1'b0, 0);
      gmode = 1;
      run(40, 1'b0, '0, '0, "R6");
      errs = 0;
      for (int n = 0; n < 4 * NAL; n++) begin
         exp_op(n, we, a, d);
         if (tr_we[n] !== we || tr_addr[n] !== a || (we && tr_data[n] !== d)) errs++;
      end
      chk(errs == 0, "R3", "address-line access order", errs, 0);
      errs = 0;
      for (int n = 4 * NAL; n < 64; n++) begin
         exp_op(n, we, a, d);
         if (tr_we[n] !== we || tr_addr[n] !== a || (we && tr_data[n] !== d)) errs++;
      end
      chk(errs == 0, "R4", "window access order", errs, 0);
      errs = 0;
      for (int i = 0; i < DEPTH; i++) if (!aa_seen[i]) errs++;
      chk(errs == 0, "R4", "all windows covered", errs, 0);

      // more clean runs
      for (int r = 0; r < 2; r++) begin
         prepare(0, 0, 1'b0, 0);
         gmode = r;
         run(0, 1'b0, '0, '0, "R6");
      end

      // address line faults: directed edges plus random
      for (int t = 0; t < 6; t++) begin
         k = (t % 3 == 0) ? 0 : (t % 3 == 1) ? AW - 1 : int'($urandom % AW);
         prepare((t < 3) ? 1 : 2, k, 1'b0, 0);
         gmode = t % 2;
         run(0, 1'b1, '0, DW'(k + 2), "R3");
      end

      // data bit faults: directed cells 3 and DEPTH-1, then random
      for (int t = 0; t < 5; t++) begin
         if (t == 0) begin c = 3; b = 0; v = 1'b0; end
         else if (t == 1) begin c = DEPTH - 1; b = 1; v = 1'b1; end
         else begin
            c = 0;
            while (is_al(c)) c = int'($urandom % DEPTH);
            b = int'($urandom % DW); v = 1'($urandom);
         end
         prepare(3, b, v, c);
         gmode = t % 2;
         run(0, 1'b1, AW'(c), exp_stuck_data(b, v), "R5");
         chk(wr_beyond == 0, "R7", "writes past failing window", wr_beyond, 0);
      end

      // restart after failures clears the flag
      prepare(0, 0, 1'b0, 0);
      gmode = 1;
      run(0, 1'b0, '0, '0, "R9");

      chk(we_noreq == 0, "R10", "write strobe without request", we_noreq, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule